// File: doc/BRIEF.md
# Chained 48-Stage Programmable Feedback Shift Register

This block joins two 24-bit programmable feedback shift registers, called half A (upper) and half B (lower), into a single 48-stage cyclic-code register. It serves as the polynomial engine for encoding and decoding burst-error-correcting cyclic codes, such as Fire codes, whose generator degree is at most 48. An external sequencer drives the shift-enable and the serial data bit. That sequencer also presents the tap masks, the feedback pick mask and the zero-detect select masks.

On each enabled shift, the chain moves one place toward the top of half A, and the top of half B crosses into the bottom of half A. A mixing bit enters at stage 0. It is the serial input, when input is enabled, XORed with one feedback bit taken from half A. The mixing bit is also XORed into every stage whose tap bit is set (Galois form). Either half can be loaded in parallel, and both are always visible as outputs. A combinational zero-detect flag reports whether every selected bit of both halves is clear.

Top module: `chained_lfsr48`

## Requirements
- R1: After reset, both halves read zero and zero_det is 1.
- R2: On a shift with no load, stage i of the 48-bit chain {reg_a, reg_b} takes the value of stage i-1 for i from 1 to 47 (before tap XOR), so reg_b bit 23 moves into reg_a bit 0.
- R3: The feedback bit is the bit of reg_a at the single position set in fb_pick; when fb_pick is zero, the feedback bit is 0; fb_pick holds at most one set bit.
- R4: The mixing bit is din XOR feedback when in_en is 1, and feedback alone when in_en is 0, in which case din has no effect. The mixing bit enters chain stage 0 (reg_b bit 0).
- R5: On a shift, chain stage i (1..47) is additionally XORed with the mixing bit when tap bit i of {tap_a, tap_b} is set; tap_b bit 0 has no effect.
- R6: With shift_en at 0 and no load, both halves hold their values.
- R7: load_a writes ld_a into reg_a and load_b writes ld_b into reg_b on the clock edge. Any load suppresses shifting in that cycle, and a half that is not loaded holds its value.
- R8: zero_det is 1 exactly when (reg_a & sel_a) and (reg_b & sel_b) are both zero, so all-zero selects give 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_en | input | 1 | Advance the chain one stage |
| in_en | input | 1 | Admit din into the mixing bit |
| din | input | 1 | Serial data bit |
| load_a | input | 1 | Parallel load of half A |
| load_b | input | 1 | Parallel load of half B |
| ld_a | input | 24 | Load value for half A |
| ld_b | input | 24 | Load value for half B |
| tap_a | input | 24 | Galois tap mask, chain stages 24..47 |
| tap_b | input | 24 | Galois tap mask, chain stages 0..23 |
| fb_pick | input | 24 | One-hot pick of the feedback bit in half A |
| sel_a | input | 24 | Zero-detect select for half A |
| sel_b | input | 24 | Zero-detect select for half B |
| reg_a | output | 24 | Current contents of half A |
| reg_b | output | 24 | Current contents of half B |
| zero_det | output | 1 | All selected bits are zero |

## Verification
The bench checks the crossing from the top of half B into the bottom of half A. A design that shifted the halves independently would lose that bit or wrap it around.

It checks feedback picked from a low position and from the top position of half A. A design that took the chain MSB instead would diverge after a few shifts. It checks that tap_b bit 0 cannot cancel the incoming bit, and that din is ignored with input disabled.

Load during an active shift must win and must leave the other half frozen; a design that shifted the unloaded half would show a moved value. Zero detect is checked with an empty select, with a set bit in only one half, and with set bits lying outside the selects.

// File: rtl/chained_lfsr48.sv
module chained_lfsr48 #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         in_en,
  input  logic         din,
  input  logic         load_a,
  input  logic         load_b,
  input  logic [W-1:0] ld_a,
  input  logic [W-1:0] ld_b,
  input  logic [W-1:0] tap_a,
  input  logic [W-1:0] tap_b,
  input  logic [W-1:0] fb_pick,
  input  logic [W-1:0] sel_a,
  input  logic [W-1:0] sel_b,
  output logic [W-1:0] reg_a,
  output logic [W-1:0] reg_b,
  output logic         zero_det
);
  localparam int N = 2 * W;

  logic [N-1:0] chain, taps, nxt;
  logic         fb, mix;

  assign chain = {reg_a, reg_b};
  assign taps  = {tap_a, tap_b[W-1:1], 1'b0};
  assign fb    = |(reg_a & fb_pick);
  assign mix   = (in_en & din) ^ fb;
  assign nxt   = {chain[N-2:0], mix} ^ (taps & {N{mix}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_a <= '0;
      reg_b <= '0;
    end else if (load_a || load_b) begin
      if (load_a) reg_a <= ld_a;
      if (load_b) reg_b <= ld_b;
    end else if (shift_en) begin
      {reg_a, reg_b} <= nxt;
    end
  end

  assign zero_det = ~|(reg_a & sel_a) & ~|(reg_b & sel_b);

  assert_fb_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fb_pick));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !load_a && !load_b) |=> ($stable(reg_a) && $stable(reg_b)));

  assert_load_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_a |=> reg_a == $past(ld_a));

  assert_load_b_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_b && !load_a) |=> (reg_b == $past(ld_b) && $stable(reg_a)));

  assert_stage0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !load_a && !load_b) |=> reg_b[0] == $past(mix));

  assert_cross_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !load_a && !load_b && !tap_a[0]) |=> reg_a[0] == $past(reg_b[W-1]));
endmodule

// File: tb/sim_chained_lfsr48.sv
module sim_chained_lfsr48;
  logic clk = 0;
  logic rst_n, shift_en, in_en, din, load_a, load_b;
  logic [23:0] ld_a, ld_b, tap_a, tap_b, fb_pick, sel_a, sel_b;
  logic [23:0] reg_a, reg_b;
  logic zero_det;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [23:0] ea, eb;

  always #4 clk = ~clk;

  chained_lfsr48 u0 (.*);

  localparam logic [23:0] VA [6] = '{24'h000000, 24'h800000, 24'h000000, 24'h123456, 24'hFFFFFF, 24'h00F0F0};
  localparam logic [23:0] VB [6] = '{24'h800001, 24'h000000, 24'h000000, 24'h789ABC, 24'h000000, 24'hABCDEF};
  localparam logic [23:0] TA [6] = '{24'h000000, 24'h000000, 24'h400000, 24'h000010, 24'h000000, 24'h810000};
  localparam logic [23:0] TB [6] = '{24'h000000, 24'h000005, 24'h000102, 24'h800021, 24'h000001, 24'h00400A};
  localparam bit          FE [6] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam int          FI [6] = '{0, 23, 23, 10, 0, 23};
  localparam bit          IE [6] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam logic [7:0]  DV [6] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'hFF, 8'hFF};
  localparam int          NS [6] = '{8, 8, 8, 16, 5, 12};

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic model(input bit ie, input bit d);
    logic [47:0] c, n;
    logic [47:0] t;
    logic f, m;
    c = {ea, eb};
    t = {tap_a, tap_b};
    f = 1'b0;
    for (int i = 0; i < 24; i++) if (fb_pick[i]) f = ea[i];
    m = (ie && d) ? ~f : f;
    n[0] = m;
    for (int i = 1; i < 48; i++) n[i] = c[i-1] ^ (t[i] & m);
    {ea, eb} = n;
  endtask

  task automatic idle;
    shift_en = 0; in_en = 0; din = 0; load_a = 0; load_b = 0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle();
    ld_a = 0; ld_b = 0; tap_a = 0; tap_b = 0; fb_pick = 0; sel_a = 0; sel_b = 0;
    rst_n = 0;
    @(negedge clk); tick();
    rst_n = 1;
    sel_a = 24'hFFFFFF; sel_b = 24'hFFFFFF;
    #1;
    chk(reg_a == 0 && reg_b == 0, "R1 reset regs", {reg_a, reg_b}, 48'h0);
    chk(zero_det == 1, "R1 reset zero_det", {47'h0, zero_det}, 48'h1);

    for (int v = 0; v < 6; v++) begin
      idle();
      ld_a = VA[v]; ld_b = VB[v]; load_a = 1; load_b = 1;
      tick();
      load_a = 0; load_b = 0;
      ea = VA[v]; eb = VB[v];
      tap_a = TA[v]; tap_b = TB[v];
      fb_pick = FE[v] ? (24'd1 << FI[v]) : 24'd0;
      shift_en = 1; in_en = IE[v];
      for (int k = 0; k < NS[v]; k++) begin
        din = DV[v][k % 8];
        model(IE[v], din);
        tick();
      end
      chk({reg_a, reg_b} == {ea, eb}, "R2/R3/R4/R5 vector", {reg_a, reg_b}, {ea, eb});
    end

    idle(); tap_a = 0; tap_b = 0; fb_pick = 0;
    ld_a = 24'h000000; ld_b = 24'h800000; load_a = 1; load_b = 1; tick();
    idle(); shift_en = 1; tick();
    chk(reg_a == 24'h000001 && reg_b == 24'h000000, "R2 cross into A", {reg_a, reg_b}, 48'h000001_000000);

    idle(); tap_b = 24'h000001; fb_pick = 24'h000001;
    ld_a = 24'h000001; ld_b = 24'h000000; load_a = 1; load_b = 1; tick();
    idle(); shift_en = 1; tick();
    chk(reg_a == 24'h000002 && reg_b == 24'h000001, "R5 tap_b bit0 no effect", {reg_a, reg_b}, 48'h000002_000001);

    idle(); tap_b = 0; fb_pick = 0;
    ld_a = 24'h000000; ld_b = 24'h000000; load_a = 1; load_b = 1; tick();
    idle(); shift_en = 1; in_en = 0; din = 1; tick();
    chk(reg_b == 0 && reg_a == 0, "R4 din ignored", {reg_a, reg_b}, 48'h0);
    in_en = 1; din = 1; tick();
    chk(reg_b == 24'h000001, "R4 din admitted", {24'h0, reg_b}, 48'h1);
    fb_pick = 0;

    idle(); ld_a = 24'hABCDEF; ld_b = 24'h123456; load_a = 1; load_b = 1; tick();
    idle(); repeat (3) tick();
    chk(reg_a == 24'hABCDEF && reg_b == 24'h123456, "R6 hold", {reg_a, reg_b}, 48'hABCDEF_123456);

    shift_en = 1; load_a = 1; ld_a = 24'h0F0F0F; tick();
    chk(reg_a == 24'h0F0F0F && reg_b == 24'h123456, "R7 load A wins", {reg_a, reg_b}, 48'h0F0F0F_123456);
    idle(); shift_en = 1; load_b = 1; ld_b = 24'h555555; tick();
    chk(reg_a == 24'h0F0F0F && reg_b == 24'h555555, "R7 load B wins", {reg_a, reg_b}, 48'h0F0F0F_555555);

    idle();
    sel_a = 0; sel_b = 0; #1;
    chk(zero_det == 1, "R8 empty select", {47'h0, zero_det}, 48'h1);
    sel_a = 24'hF0F0F0; sel_b = 24'hAAAAAA; #1;
    chk(zero_det == 1, "R8 set bits outside select", {47'h0, zero_det}, 48'h1);
    sel_b = 24'h000001; #1;
    chk(zero_det == 0, "R8 set bit in B", {47'h0, zero_det}, 48'h0);
    sel_b = 0; sel_a = 24'h000100; #1;
    chk(zero_det == 0, "R8 set bit in A", {47'h0, zero_det}, 48'h0);

    rst_n = 0; tick(); rst_n = 1; sel_a = 24'hFFFFFF; sel_b = 24'hFFFFFF; #1;
    chk(reg_a == 0 && reg_b == 0 && zero_det, "R1 reset after use", {reg_a, reg_b}, 48'h0);

    finish_run();
  end
endmodule